// File: doc/BRIEF.md
# Descriptor-Driven Audio Read Channel

This block is a single channel of an audio DMA engine that walks a list of two-word descriptors in memory. Each descriptor gives a buffer address and a word packing end-of-block flags with a byte count. The channel reads each buffer one 32-bit word at a time and pushes the words into a small FIFO. A downstream consumer drains that FIFO through a valid/ready stream. When a block ends, the descriptor flags decide whether the channel pauses, raises an event, loops back to the table base, or finishes.

The host side is a plain write port with three targets. Select 0 is the control register. In that write, bits 3:0 are stored as control, bit 7 is a start command and bit 6 queues a trigger. Select 1 clears status bits by writing 1 to them. Select 2 loads the table base. The status byte uses bit 0 for block event, bit 1 for end of list, bit 2 for halted, bit 3 for trigger queued and bit 7 for running. The control bits are: bit 0 enables the event interrupt, bit 1 enables the end-of-list interrupt, bit 2 enables the halt interrupt, and bit 3 sets loop mode.

The memory port is a request/response pair. A request holds its address until it is accepted, and only one request is in flight at a time. The response is taken only while `mem_rsp_ready` is high. On the FIFO side, `out_data` is held while `out_valid` is high and `out_ready` is low. A full FIFO stops further memory reads rather than dropping data.

Top module: `sgdma_channel`

## Requirements
- R1: After reset, status, control and base read 0, and `irq`, `mem_req_valid` and `out_valid` are low.
- R2: A base write stores the written value with bit 0 forced to 0.
- R3: A start command sets status bit 7, clears status bit 2, and the next two requests read the descriptor words at the base and at base+4.
- R4: The second descriptor word carries flags in bits 31:24 and the byte count in bits 23:0. The channel reads count/4 data words from the buffer address upward in steps of 4 and presents them on `out_data` in that order.
- R5: After a block whose flags select no halt and no end of list, the next descriptor is fetched from the 8 bytes following the previous one.
- R6: Flag bit 5 sets status bit 2 when its block ends, and no further request is issued. Writing 1 to status bit 2 resumes the channel at the following descriptor.
- R7: Flag bit 6 sets status bit 0 when its block ends, and the channel keeps going.
- R8: Flag bit 7 sets status bit 1. If control bit 3 or status bit 3 is set, status bit 3 is cleared and the channel restarts from the table base. Otherwise status bit 7 is cleared and the channel stops.
- R9: No data read is issued while the FIFO is full, and `out_data` stays stable while `out_valid` is high and `out_ready` is low.
- R10: `irq` is high exactly when one of status bits 0..2 is set together with the control bit at the same position. Writing 1 to a status bit clears it.
- R11: `mem_req_valid` and `mem_req_addr` are held steady until `mem_req_ready` is high.
- R12: A control write with bit 6 set sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Host write strobe |
| cfg_wr_sel | input | 2 | Write target: 0 control, 1 status clear, 2 base |
| cfg_wdata | input | 32 | Host write data |
| ctrl_q | output | 4 | Control bits (interrupt enables, loop) |
| status_q | output | 8 | Status byte |
| base_q | output | 32 | Descriptor table base |
| irq | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Channel accepts read data |
| mem_rsp_data | input | 32 | Memory read data |
| out_valid | output | 1 | FIFO word available |
| out_ready | input | 1 | Consumer takes FIFO word |
| out_data | output | 32 | FIFO word |

## Verification
A wrong entry pointer or restart mode shows up as a wrong address on the memory request port. It appears at the first descriptor fetch after the block boundary, within a few cycles of the end of the last data word. Mishandled flags show in the status byte and on `irq` one cycle after the block ends. A halt that is not honoured shows as a request issued while status bit 2 is set. FIFO pointer faults show as reordered, duplicated or missing words when the stream is drained, or as reads that continue while the consumer stalls.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_D0_REQ, ST_D0_WAIT, ST_D1_REQ, ST_D1_WAIT,
    ST_DAT_REQ, ST_DAT_WAIT, ST_END
  } eng_state_e;

  typedef enum logic [1:0] {RS_NONE, RS_NEXT, RS_BASE} restart_e;

  localparam int SB_EVENT  = 0;
  localparam int SB_EOL    = 1;
  localparam int SB_HALT   = 2;
  localparam int SB_QUEUED = 3;
  localparam int SB_RUN    = 7;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_BASE   = 2'd2;

  typedef struct packed {
    logic ev_event;
    logic ev_eol;
    logic ev_halt;
    logic ev_finish;
    logic ev_unqueue;
  } eng_evt_t;
endpackage

// File: rtl/sgdma_fifo.sv
module sgdma_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic [AW:0]  level,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  assign out_valid = (level != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_valid) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_valid, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (level < (AW+1)'(DEPTH)));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  eng_evt_t          evt,
  output logic [3:0]        ctrl_q,
  output logic [7:0]        status_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              start_pulse,
  output logic              irq
);
  localparam logic [7:0] W1C_MASK = 8'h87;

  logic       ctrl_wr;
  logic [7:0] stat_nx;

  assign ctrl_wr     = cfg_wr_en && (cfg_wr_sel == SEL_CTRL);
  assign start_pulse = ctrl_wr && cfg_wdata[7];
  assign irq         = |(status_q[2:0] & ctrl_q[2:0]);

  always_comb begin
    stat_nx = status_q;
    if (cfg_wr_en && (cfg_wr_sel == SEL_STATUS))
      stat_nx = stat_nx & ~(cfg_wdata[7:0] & W1C_MASK);
    if (evt.ev_event)   stat_nx[SB_EVENT]  = 1'b1;
    if (evt.ev_eol)     stat_nx[SB_EOL]    = 1'b1;
    if (evt.ev_halt)    stat_nx[SB_HALT]   = 1'b1;
    if (evt.ev_finish)  stat_nx[SB_RUN]    = 1'b0;
    if (evt.ev_unqueue) stat_nx[SB_QUEUED] = 1'b0;
    if (ctrl_wr && cfg_wdata[6]) stat_nx[SB_QUEUED] = 1'b1;
    if (start_pulse) begin
      stat_nx[SB_RUN]  = 1'b1;
      stat_nx[SB_HALT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
      base_q   <= '0;
    end else begin
      status_q <= stat_nx;
      if (ctrl_wr) ctrl_q <= cfg_wdata[3:0];
      if (cfg_wr_en && (cfg_wr_sel == SEL_BASE))
        base_q <= {cfg_wdata[ADDR_W-1:1], 1'b0};
    end
  end

  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ev_event |=> status_q[SB_EVENT]);

  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (status_q[SB_RUN] && !status_q[SB_HALT]));

  p_queue_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cfg_wdata[6]) |=> status_q[SB_QUEUED]);
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 24,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WC_W  = CNT_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_q,
  input  logic              loop_en,
  input  logic [7:0]        status_q,
  input  logic              start_pulse,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic [AW:0]       fifo_level,
  output logic              push_valid,
  output logic [DW-1:0]     push_data,
  output eng_evt_t          evt
);
  eng_state_e        state;
  restart_e          restart;
  logic              start_pend;
  logic [ADDR_W-1:0] entry_ptr, sample_ptr;
  logic [WC_W-1:0]   words_left;
  logic [2:0]        dflags;   // {eol, event, halt}
  logic              run, room, do_loop;

  assign run     = status_q[SB_RUN] && !status_q[SB_HALT];
  assign room    = fifo_level < (AW+1)'(DEPTH);
  assign do_loop = loop_en || status_q[SB_QUEUED];

  assign mem_req_valid = (state == ST_D0_REQ) || (state == ST_D1_REQ) || (state == ST_DAT_REQ);
  assign mem_req_addr  = (state == ST_DAT_REQ) ? sample_ptr : entry_ptr;
  assign mem_rsp_ready = (state == ST_D0_WAIT) || (state == ST_D1_WAIT) || (state == ST_DAT_WAIT);
  assign push_valid    = (state == ST_DAT_WAIT) && mem_rsp_valid;
  assign push_data     = mem_rsp_data;

  always_comb begin
    evt = '0;
    if (state == ST_END) begin
      evt.ev_halt    = dflags[0];
      evt.ev_event   = dflags[1];
      evt.ev_eol     = dflags[2];
      evt.ev_unqueue = dflags[2] && do_loop;
      evt.ev_finish  = dflags[2] && !do_loop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      restart    <= RS_NONE;
      start_pend <= 1'b0;
      entry_ptr  <= '0;
      sample_ptr <= '0;
      words_left <= '0;
      dflags     <= '0;
    end else begin
      if (start_pulse) start_pend <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start_pend) begin
            start_pend <= start_pulse;
            restart    <= RS_BASE;
            sample_ptr <= '0;
            words_left <= '0;
          end else if (run && room) begin
            if (restart != RS_NONE) begin
              if (restart == RS_BASE) entry_ptr <= base_q;
              restart <= RS_NONE;
              state   <= ST_D0_REQ;
            end else if (words_left != '0) begin
              state <= ST_DAT_REQ;
            end else begin
              state <= ST_END;
            end
          end
        end
        ST_D0_REQ: if (mem_req_ready) begin
          entry_ptr <= entry_ptr + ADDR_W'(4);
          state     <= ST_D0_WAIT;
        end
        ST_D0_WAIT: if (mem_rsp_valid) begin
          sample_ptr <= mem_rsp_data[ADDR_W-1:0];
          state      <= ST_D1_REQ;
        end
        ST_D1_REQ: if (mem_req_ready) begin
          entry_ptr <= entry_ptr + ADDR_W'(4);
          state     <= ST_D1_WAIT;
        end
        ST_D1_WAIT: if (mem_rsp_valid) begin
          dflags     <= mem_rsp_data[31:29];
          words_left <= mem_rsp_data[CNT_W-1:2];
          state      <= (mem_rsp_data[CNT_W-1:2] == '0) ? ST_END : ST_IDLE;
        end
        ST_DAT_REQ: if (mem_req_ready) begin
          sample_ptr <= sample_ptr + ADDR_W'(4);
          state      <= ST_DAT_WAIT;
        end
        ST_DAT_WAIT: if (mem_rsp_valid) begin
          words_left <= words_left - 1'b1;
          state      <= (words_left == WC_W'(1)) ? ST_END : ST_IDLE;
        end
        ST_END: begin
          restart <= (dflags[2] && do_loop) ? RS_BASE : RS_NEXT;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DAT_REQ) |-> (fifo_level < (AW+1)'(DEPTH)));

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && status_q[SB_HALT]) |=> !mem_req_valid);

  p_desc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_D0_REQ) || (state == ST_D1_REQ)) |-> !mem_req_addr[0]);
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 24,
  localparam int AW        = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [3:0]        ctrl_q,
  output logic [7:0]        status_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data
);
  eng_evt_t      evt;
  logic          start_pulse;
  logic          push_valid;
  logic [DW-1:0] push_data;
  logic [AW:0]   fifo_level;

  sgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_sel, .cfg_wdata, .evt,
    .ctrl_q, .status_q, .base_q, .start_pulse, .irq
  );

  sgdma_engine #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_engine (
    .clk, .rst_n, .base_q, .loop_en(ctrl_q[3]), .status_q, .start_pulse,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .fifo_level, .push_valid, .push_data, .evt
  );

  sgdma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push_valid, .push_data, .level(fifo_level),
    .out_valid, .out_ready, .out_data
  );
endmodule

// File: tb/tb_sgdma_channel.sv
module tb_sgdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  ctrl_q;
  logic [7:0]  status_q;
  logic [31:0] base_q;
  logic        irq;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [256];
  logic [31:0] req_log [64];
  logic [31:0] pop_log [64];
  int req_n = 0;
  int pop_n = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always #10 clk = ~clk;

  sgdma_channel dut (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_sel, .cfg_wdata, .ctrl_q, .status_q,
    .base_q, .irq, .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data, .out_valid, .out_ready, .out_data
  );

  // memory responder and stream logger, both acting at the falling edge
  always @(negedge clk) begin
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[pend_addr[9:2]];
      pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1'b1;
      pend_addr = mem_req_addr;
      if (req_n < 64) req_log[req_n] = mem_req_addr;
      req_n++;
    end
    if (rst_n && out_valid && out_ready) begin
      if (pop_n < 64) pop_log[pop_n] = out_data;
      pop_n++;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    step();
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wdata = data;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (status_q[7] && n < 500) begin step(); n++; end
    chk(req, 32'(status_q[7]), 32'd0);
  endtask

  task automatic clear_logs();
    req_n = 0; pop_n = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status_q), 32'h0);
    chk("R1 ctrl", 32'(ctrl_q), 32'h0);
    chk("R1 base", base_q, 32'h0);
    chk("R1 irq/req/out", {29'd0, irq, mem_req_valid, out_valid}, 32'h0);
  endtask

  task automatic t_base();
    wr(2, 32'h0000_0101);
    chk("R2 base lsb forced", base_q, 32'h0000_0100);
  endtask

  // two descriptors: plain block, then event+end-of-list
  task automatic t_basic();
    logic [31:0] exp_req [9] = '{32'h100, 32'h104, 32'h200, 32'h204,
                                 32'h108, 32'h10C, 32'h210, 32'h214, 32'h218};
    logic [31:0] exp_pop [5];
    exp_pop = '{mem[8'h80], mem[8'h81], mem[8'h84], mem[8'h85], mem[8'h86]};
    clear_logs();
    wr(0, 32'h80);
    chk("R3 running after start", 32'(status_q[7]), 32'd1);
    wait_idle("R8 finish at end of list");
    repeat (4) step();
    chk("R3/R5 request count", 32'(req_n), 32'd9);
    for (int k = 0; k < 9; k++) chk("R3/R4/R5 request address", req_log[k], exp_req[k]);
    chk("R4 word count", 32'(pop_n), 32'd5);
    for (int k = 0; k < 5; k++) chk("R4 stream order", pop_log[k], exp_pop[k]);
    chk("R7/R8 status event+eol", 32'(status_q), 32'h03);
    chk("R10 irq masked", 32'(irq), 32'd0);
    wr(1, 32'hFF);
    chk("R10 w1c clears", 32'(status_q), 32'h0);
  endtask

  task automatic t_halt();
    int n = 0;
    wr(2, 32'h180);
    clear_logs();
    wr(0, 32'h84);
    while (!status_q[2] && n < 200) begin step(); n++; end
    repeat (20) step();
    chk("R6 no request while halted", 32'(req_n), 32'd3);
    chk("R6 halted status", 32'(status_q), 32'h84);
    chk("R10 irq on halt", 32'(irq), 32'd1);
    wr(1, 32'h04);
    wait_idle("R8 finish after resume");
    repeat (4) step();
    chk("R6 resume count", 32'(req_n), 32'd6);
    chk("R6 resume next descriptor", req_log[3], 32'h188);
    chk("R6 resume data address", req_log[5], 32'h250);
    chk("R6 data words", 32'(pop_n), 32'd2);
    chk("R8 status after finish", 32'(status_q), 32'h02);
    chk("R10 irq cleared", 32'(irq), 32'd0);
    wr(1, 32'hFF);
  endtask

  task automatic t_loop();
    int n = 0;
    logic [31:0] exp_req [6] = '{32'h1C0, 32'h1C4, 32'h280, 32'h1C0, 32'h1C4, 32'h280};
    wr(2, 32'h1C0);
    clear_logs();
    wr(0, 32'h88);
    while (req_n < 6 && n < 300) begin step(); n++; end
    wr(0, 32'h00);
    wait_idle("R8 loop ends when loop bit cleared");
    for (int k = 0; k < 6; k++) chk("R8 loop back to base", req_log[k], exp_req[k]);
    chk("R8 whole passes", 32'(req_n % 3), 32'd0);
    chk("R8 eol after loop", 32'(status_q), 32'h02);
    wr(1, 32'hFF);
    // queued trigger: one extra pass, then finish
    clear_logs();
    wr(0, 32'h80);
    wr(0, 32'h40);
    chk("R12 queued bit set", 32'(status_q[3]), 32'd1);
    wait_idle("R8 finish after queued pass");
    repeat (4) step();
    chk("R8 queued gives one extra pass", 32'(req_n), 32'd6);
    chk("R8 queued cleared", 32'(status_q), 32'h02);
    wr(1, 32'hFF);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    wr(2, 32'h1E0);
    clear_logs();
    out_ready = 1'b0;
    mem_req_ready = 1'b0;
    wr(0, 32'h80);
    repeat (6) step();
    chk("R11 request held valid", 32'(mem_req_valid), 32'd1);
    chk("R11 request address held", mem_req_addr, 32'h1E0);
    mem_req_ready = 1'b1;
    repeat (60) step();
    chk("R9 reads stop at full fifo", 32'(req_n), 32'd6);
    chk("R9 output valid", 32'(out_valid), 32'd1);
    held = out_data;
    chk("R9 head word", held, mem[8'hB0]);
    repeat (3) step();
    chk("R9 head stable", out_data, held);
    out_ready = 1'b1;
    wait_idle("R8 finish after drain");
    repeat (10) step();
    chk("R9 all words delivered", 32'(pop_n), 32'd8);
    for (int k = 0; k < 8; k++) chk("R4/R9 drained order", pop_log[k], mem[8'hB0 + k]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | 32'(i * 32'h101);
    mem[8'h40] = 32'h200; mem[8'h41] = {8'h00, 24'd8};
    mem[8'h42] = 32'h210; mem[8'h43] = {8'hC0, 24'd12};
    mem[8'h60] = 32'h240; mem[8'h61] = {8'h20, 24'd4};
    mem[8'h62] = 32'h250; mem[8'h63] = {8'h80, 24'd4};
    mem[8'h70] = 32'h280; mem[8'h71] = {8'h80, 24'd4};
    mem[8'h78] = 32'h2C0; mem[8'h79] = {8'h80, 24'd32};
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_base();
    t_basic();
    t_halt();
    t_loop();
    t_backpressure();
    summary();
  end
endmodule